// File: doc/BRIEF.md
# Direct-Page Single-Bit Operation Unit

This unit carries out one single-bit instruction on a byte in the lowest 256 locations of memory. There are two kinds of instruction. The first kind sets or clears one bit of the byte. The second kind tests one bit and branches when that bit has the requested value. The caller presents the opcode, the direct address byte, the displacement byte (used only by branches), the address of the opcode, and the current carry flag, and pulses `start` for one cycle. The opcode selects the bit number and the polarity.

The unit then runs a short sequence on a synchronous single-port memory. It reads the addressed byte, evaluates it, and for set or clear writes back the modified byte. At the end it presents the new carry flag, a branch-taken flag and the address of the next instruction, and it marks completion with a one-cycle `done` pulse. These results stay valid until the next accepted start. Opcode fetch, all other instructions and interrupts belong to the surrounding core.

Top module: `bitop_unit`

## Requirements
- R1: Opcode decode works as follows. Bits 7:5 equal to 000 select test-and-branch. Bits 7:5 equal to 001 select bit set/clear. Bits 3:1 give the bit number, 0 to 7. Bit 0 equal to 0 means set, or branch-if-set. Bit 0 equal to 1 means clear, or branch-if-clear. Bit 4 is ignored.
- R2: A set instruction writes back the addressed byte with the selected bit forced to 1 and every other bit unchanged. The write goes to the direct address byte, which ranges from 0x00 to 0xFF.
- R3: A clear instruction writes back the addressed byte with the selected bit forced to 0 and every other bit unchanged.
- R4: For set or clear, `carry_out` equals `carry_in` as sampled at start, `br_taken` is 0, and `next_pc` is the opcode address plus 2, modulo 2^PC_W.
- R5: A test-and-branch is taken when the selected bit equals 1 for branch-if-set, or equals 0 for branch-if-clear. When taken, `next_pc` is the opcode address plus 3 plus the sign-extended displacement, giving a range of -128 to +127 from the next opcode. When not taken, `next_pc` is the opcode address plus 3. A test-and-branch never writes memory.
- R6: On every test-and-branch, taken or not, `carry_out` receives the value of the tested bit.
- R7: Memory timing is fixed. `mem_rd` is high in the cycle after `start` is captured, with `mem_addr` set to the direct address. `mem_rdata` is used in the following cycle, which is also the single cycle in which `mem_wr` pulses for set or clear. `done` is high for exactly one cycle, the third cycle after the start-capture edge. The results hold until the next accepted start.
- R8: A `start` while `busy` is high is ignored. A `start` whose opcode bits 7:5 are neither 000 nor 001 is ignored: no memory access, no `done` pulse, and no change to the results.
- R9: After synchronous active-low reset, `done`, `br_taken`, `carry_out`, `busy`, `mem_rd` and `mem_wr` are 0 and `next_pc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run an instruction |
| opcode | input | 8 | Instruction opcode (class, bit number, polarity) |
| dir_addr | input | 8 | Direct address of the operand byte |
| disp | input | 8 | Signed branch displacement |
| op_pc | input | PC_W | Address of the opcode byte |
| carry_in | input | 1 | Carry flag before the instruction |
| busy | output | 1 | High while an instruction is in progress |
| mem_addr | output | 8 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| carry_out | output | 1 | Updated carry flag |
| br_taken | output | 1 | Branch taken |
| next_pc | output | PC_W | Address of the next instruction |
| done | output | 1 | One-cycle completion pulse |

## Verification
Inputs change on the falling edge. If `start` is captured at a rising edge, `mem_rd` is visible on the next falling edge, the write strobe on the second one, and `done` together with the final results on the third. Each scenario task samples `done` on each of those falling edges and on one more after them. It compares the results only on the falling edge where `done` is high, and re-reads them later to confirm they are held. A bench monitor counts the memory reads and writes made during each instruction. Memory contents are inspected through the bench's own memory model after `done`.

// File: rtl/bitop_pkg.sv
// Package: shared types for the direct-page single-bit operation unit.
// Assumes an 8-bit opcode and an 8-bit data byte.
package bitop_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = $clog2(BYTE_W);

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EVAL = 2'd2,
        ST_FIN  = 2'd3
    } state_t;

    // Instruction kinds produced by the decoder
    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_BRANCH = 2'd1,
        K_MODIFY = 2'd2
    } kind_t;

    // Decoded instruction
    typedef struct packed {
        kind_t             kind;
        logic [SEL_W-1:0]  bit_sel;
        logic              neg;      // 1 = clear / branch-if-clear
    } dec_t;

endpackage

// File: rtl/bitop_decode.sv
// Module: bitop_decode
// Splits an opcode into kind, bit number and polarity.
// Assumes class in bits 7:5, bit number in bits 3:1, polarity in bit 0.
module bitop_decode
    import bitop_pkg::*;
#(
    parameter logic [2:0] CLASS_BRANCH = 3'b000,
    parameter logic [2:0] CLASS_MODIFY = 3'b001
) (
    input  logic [7:0] opcode,
    output dec_t       dec
);

    logic [2:0] op_class;
    assign op_class = opcode[7:5];

    // Purpose: map the opcode fields onto the decoded record.
    always_comb begin
        dec.bit_sel = opcode[3:1];
        dec.neg     = opcode[0];
        if (op_class == CLASS_BRANCH) begin
            dec.kind = K_BRANCH;
        end else if (op_class == CLASS_MODIFY) begin
            dec.kind = K_MODIFY;
        end else begin
            dec.kind = K_NONE;
        end
    end

endmodule

// File: rtl/bitop_bitlogic.sv
// Module: bitop_bitlogic
// Pure datapath: extracts the selected bit and forms the modified byte.
// Assumes DATA_W is a power of two so that the selector covers every bit.
module bitop_bitlogic #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SW    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] rd_byte,
    input  logic [SW-1:0]     bit_sel,
    input  logic              clear,
    output logic [DATA_W-1:0] wr_byte,
    output logic              tested
);

    logic [DATA_W-1:0] onehot;

    // Purpose: per-bit select line and merge of the new value.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign onehot[i]  = (bit_sel == SW'(i));
        assign wr_byte[i] = onehot[i] ? ~clear : rd_byte[i];
    end

    assign tested = |(rd_byte & onehot);

    // R2 R3: the write-back differs from the read byte in at most one position
    always_comb begin
        single_bit_chk: assert ($countones(wr_byte ^ rd_byte) <= 1);
    end

endmodule

// File: rtl/bitop_target.sv
// Module: bitop_target
// Computes the next-instruction address from the opcode address.
// Assumes set/clear is 2 bytes long and test-and-branch is 3 bytes long.
// Addresses wrap modulo 2^PC_W.
module bitop_target #(
    parameter int unsigned PC_W = 16
) (
    input  logic [PC_W-1:0] op_pc,
    input  logic [7:0]      disp,
    input  logic            is_branch,
    input  logic            taken,
    output logic [PC_W-1:0] next_pc
);

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp_ext;

    // Purpose: sequential address for the instruction length, plus the
    // sign-extended displacement when the branch is taken.
    always_comb begin
        seq_pc   = op_pc + (is_branch ? PC_W'(3) : PC_W'(2));
        disp_ext = {{(PC_W-8){disp[7]}}, disp};
        next_pc  = taken ? (seq_pc + disp_ext) : seq_pc;
    end

endmodule

// File: rtl/bitop_unit.sv
// Module: bitop_unit (top)
// Runs one set/clear/test-and-branch instruction on a direct-page byte.
// Sequence: IDLE -> READ (strobe read) -> EVAL (data valid; write for
// set/clear; results registered) -> FIN (done pulse) -> IDLE.
// Assumes a synchronous memory that returns data the cycle after mem_rd.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int unsigned PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      opcode,
    input  logic [7:0]      dir_addr,
    input  logic [7:0]      disp,
    input  logic [PC_W-1:0] op_pc,
    input  logic            carry_in,
    output logic            busy,
    output logic [7:0]      mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata,
    output logic            carry_out,
    output logic            br_taken,
    output logic [PC_W-1:0] next_pc,
    output logic            done
);

    state_t          state;
    dec_t            dec_in;
    dec_t            dec_q;
    logic [7:0]      addr_q;
    logic [7:0]      disp_q;
    logic [PC_W-1:0] pc_q;
    logic            cin_q;
    logic            tested;
    logic            take_now;
    logic [PC_W-1:0] tgt_pc;
    logic            accept;

    bitop_decode u_decode (
        .opcode (opcode),
        .dec    (dec_in)
    );

    bitop_bitlogic #(.DATA_W(BYTE_W)) u_bitlogic (
        .rd_byte (mem_rdata),
        .bit_sel (dec_q.bit_sel),
        .clear   (dec_q.neg),
        .wr_byte (mem_wdata),
        .tested  (tested)
    );

    // Purpose: branch condition from the tested bit and the polarity.
    always_comb begin
        take_now = (dec_q.kind == K_BRANCH) && (tested == ~dec_q.neg);
    end

    bitop_target #(.PC_W(PC_W)) u_target (
        .op_pc     (pc_q),
        .disp      (disp_q),
        .is_branch (dec_q.kind == K_BRANCH),
        .taken     (take_now),
        .next_pc   (tgt_pc)
    );

    assign accept   = start && (state == ST_IDLE) && (dec_in.kind != K_NONE);
    assign busy     = (state != ST_IDLE);
    assign mem_addr = addr_q;
    assign mem_rd   = (state == ST_READ);
    assign mem_wr   = (state == ST_EVAL) && (dec_q.kind == K_MODIFY);

    // Purpose: sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (accept) state <= ST_READ;
                ST_READ: state <= ST_EVAL;
                ST_EVAL: state <= ST_FIN;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: capture the instruction operands when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q  <= '{kind: K_NONE, bit_sel: '0, neg: 1'b0};
            addr_q <= '0;
            disp_q <= '0;
            pc_q   <= '0;
            cin_q  <= 1'b0;
        end else if (accept) begin
            dec_q  <= dec_in;
            addr_q <= dir_addr;
            disp_q <= disp;
            pc_q   <= op_pc;
            cin_q  <= carry_in;
        end
    end

    // Purpose: register the results at the end of EVAL and raise done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_out <= 1'b0;
            br_taken  <= 1'b0;
            next_pc   <= '0;
            done      <= 1'b0;
        end else begin
            done <= (state == ST_EVAL);
            if (state == ST_EVAL) begin
                carry_out <= (dec_q.kind == K_BRANCH) ? tested : cin_q;
                br_taken  <= take_now;
                next_pc   <= tgt_pc;
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd) && $stable(mem_addr)));

    // R7
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8
    busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !mem_rd);

    // R7
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && $past(!busy)) |-> ($stable(next_pc) && $stable(carry_out) && $stable(br_taken)));

    // R4
    modify_no_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mem_wr)) |-> !br_taken);

endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
    localparam int PC_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [7:0]      opcode = '0;
    logic [7:0]      dir_addr = '0;
    logic [7:0]      disp = '0;
    logic [PC_W-1:0] op_pc = '0;
    logic            carry_in = 1'b0;
    logic            busy;
    logic [7:0]      mem_addr;
    logic            mem_rd;
    logic            mem_wr;
    logic [7:0]      mem_wdata;
    logic [7:0]      mem_rdata;
    logic            carry_out;
    logic            br_taken;
    logic [PC_W-1:0] next_pc;
    logic            done;

    int n_checks = 0;
    int n_fail   = 0;
    int rd_cnt   = 0;
    int wr_cnt   = 0;
    logic [7:0] mem [256];

    always #4 clk = ~clk;

    bitop_unit #(.PC_W(PC_W)) u_bitop_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .dir_addr(dir_addr), .disp(disp), .op_pc(op_pc), .carry_in(carry_in),
        .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .carry_out(carry_out),
        .br_taken(br_taken), .next_pc(next_pc), .done(done)
    );

    // Synchronous memory model with access counters
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr];
            rd_cnt <= rd_cnt + 1;
        end
        if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one instruction and check the done timing (R7)
    task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d,
                         input logic [PC_W-1:0] pc, input logic cin);
        logic [3:0] seen;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        start = 1'b1; opcode = op; dir_addr = a; disp = d; op_pc = pc; carry_in = cin;
        @(negedge clk); start = 1'b0; seen[0] = done;
        check(mem_rd && mem_addr == a, "R7 read strobe", {mem_rd, mem_addr}, {1'b1, a});
        @(negedge clk); seen[1] = done;
        @(negedge clk); seen[2] = done;
        @(negedge clk); seen[3] = done;
        check(seen == 4'b0100, "R7 done timing", seen, 4'b0100);
        check(rd_cnt == 1, "R7 single read", rd_cnt, 1);
    endtask

    task automatic t_set(input int b, input logic [7:0] a, input logic [7:0] init);
        logic [7:0] exp;
        mem[a] = init; mem[a+8'd1] = 8'h5A;
        exp = init | (8'h1 << b);
        issue({3'b001, 1'b0, 3'(b), 1'b0}, a, 8'h00, 16'h1234, 1'b1);
        check(mem[a] == exp, "R2 set bit", mem[a], exp);
        check(mem[a+8'd1] == 8'h5A, "R2 neighbour untouched", mem[a+8'd1], 8'h5A);
        check(wr_cnt == 1, "R2 one write", wr_cnt, 1);
        check(carry_out == 1'b1 && !br_taken && next_pc == 16'h1236, "R4 set results",
              {carry_out, br_taken, next_pc}, {2'b10, 16'h1236});
    endtask

    task automatic t_clear(input int b, input logic [7:0] a, input logic [7:0] init);
        logic [7:0] exp;
        mem[a] = init;
        exp = init & ~(8'h1 << b);
        // bit 4 set: must be ignored (R1)
        issue({3'b001, 1'b1, 3'(b), 1'b1}, a, 8'hFF, 16'hFFFF, 1'b0);
        check(mem[a] == exp, "R3 clear bit", mem[a], exp);
        check(carry_out == 1'b0 && !br_taken && next_pc == 16'h0001, "R4 clear results wrap",
              {carry_out, br_taken, next_pc}, {2'b00, 16'h0001});
    endtask

    task automatic t_branch(input int b, input logic neg, input logic [7:0] init,
                            input logic [7:0] d, input logic [PC_W-1:0] pc, input logic cin);
        logic tb;
        logic tk;
        logic [PC_W-1:0] expc;
        mem[8'h40] = init;
        tb = init[b];
        tk = (tb == !neg);
        expc = pc + 16'd3 + (tk ? {{8{d[7]}}, d} : 16'd0);
        issue({3'b000, 1'b0, 3'(b), neg}, 8'h40, d, pc, cin);
        check(br_taken == tk, "R5 taken", br_taken, tk);
        check(next_pc == expc, "R5 target", next_pc, expc);
        check(carry_out == tb, "R6 carry gets tested bit", carry_out, tb);
        check(wr_cnt == 0 && mem[8'h40] == init, "R5 no write", wr_cnt, 0);
    endtask

    task automatic t_illegal();
        logic [PC_W-1:0] pc0;
        logic c0;
        pc0 = next_pc; c0 = carry_out;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        start = 1'b1; opcode = 8'hE3; dir_addr = 8'h40; op_pc = 16'h7777; carry_in = ~c0;
        @(negedge clk); start = 1'b0;
        check(!busy, "R8 illegal not accepted", busy, 0);
        repeat (4) @(negedge clk);
        check(rd_cnt == 0 && wr_cnt == 0 && !done, "R8 illegal no access", rd_cnt + wr_cnt, 0);
        check(next_pc == pc0 && carry_out == c0, "R8 results held", next_pc, pc0);
    endtask

    task automatic t_busy_start();
        mem[8'h20] = 8'h00; mem[8'h21] = 8'h00;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        start = 1'b1; opcode = 8'h2E; dir_addr = 8'h20; op_pc = 16'h0100; carry_in = 1'b0;
        @(negedge clk);
        opcode = 8'h20; dir_addr = 8'h21; op_pc = 16'h0900;  // start still high, busy
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        check(mem[8'h20] == 8'h80 && mem[8'h21] == 8'h00, "R8 start ignored while busy",
              {mem[8'h20], mem[8'h21]}, 16'h8000);
        check(rd_cnt == 1 && next_pc == 16'h0102, "R8 one instruction only", next_pc, 16'h0102);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37);
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!done && !br_taken && !carry_out && !busy && !mem_rd && !mem_wr && next_pc == 0,
              "R9 reset", {done, br_taken, carry_out, busy, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        t_set(0, 8'h00, 8'h00);
        t_set(7, 8'hFF, 8'h7E);
        t_set(3, 8'h10, 8'hFF);
        t_clear(5, 8'h30, 8'hFF);
        t_clear(0, 8'h31, 8'h00);
        t_branch(2, 1'b0, 8'h04, 8'h7F, 16'h2000, 1'b0);   // set, taken, +127
        t_branch(2, 1'b0, 8'hFB, 8'h7F, 16'h2000, 1'b1);   // set, not taken
        t_branch(6, 1'b1, 8'hBF, 8'h80, 16'h2000, 1'b1);   // clear, taken, -128
        t_branch(6, 1'b1, 8'h40, 8'h80, 16'h2000, 1'b0);   // clear, not taken
        t_branch(7, 1'b0, 8'h80, 8'hFD, 16'h0010, 1'b0);   // -3 loops to self
        t_illegal();
        t_busy_start();
        // R7 results hold after done
        repeat (3) @(negedge clk);
        check(next_pc == 16'h0102 && !done, "R7 hold", next_pc, 16'h0102);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule